// File: doc/BRIEF.md
# SD/MMC Command Issue and Response Capture

This block is the command half of a memory-card host controller. Software, or a higher-level sequencer, writes a 32-bit argument and then a command word. When the command word has its start bit set, the block hands the 6-bit command index and the argument to a card-side engine with a one-cycle request strobe. It then gathers the response bytes that the engine returns.

When the engine signals the end of the exchange, the block judges the byte count against the response type that was asked for. If the count is valid, it packs the bytes into four 32-bit response words, with the first byte received in the most significant position. It then raises exactly one outcome event: command sent, response received, or command timeout. At completion it clears the start bit in its command register, so that a read-back shows the command has finished.

A busy flag covers the whole exchange. Command and argument writes that arrive while the flag is high are dropped.

Top module: `sdcmd_issuer`

## Requirements
- R1: A write of `cmd_wdata` while `cmd_active` is low loads `cmd_q`. If bit 10 (start) of the written word is set, `cmd_active` rises on that edge and `card_req` is high for exactly that next cycle. During that cycle `card_idx` carries bits 5:0 of the command and `card_arg` carries the last accepted argument. A write with bit 10 clear only loads `cmd_q`.
- R2: At completion, on one and the same edge, bit 10 of `cmd_q` is cleared, `cmd_active` falls, and exactly one of `evt_sent`, `evt_rsp` and `evt_tmo` pulses high for one cycle. Bits 9:0 of `cmd_q` keep their value.
- R3: `cmd_active` stays high from the start edge to the completion edge, two cycles after the cycle in which `card_done` or `card_nores` is seen. Command and argument writes made while it is high are ignored, including a write in the final busy cycle.
- R4: For a valid response, word n of `rsp_words` (bits 32n+31:32n) holds received bytes 4n to 4n+3. Byte 4n sits in bits 31:24, and each later byte sits 8 bits lower.
- R5: A valid 4-byte response fills word 0 and sets words 1 to 3 to zero.
- R6: A valid 16-byte response fills all four words, with bit 0 of word 3 forced to 0.
- R7: When bit 6 (response expected) is set, the outcome is a timeout if no bytes arrive, if 4 bytes arrive while bit 7 (long response) is set, or if the count is neither 4 nor 16. Counts above 16 also give a timeout. Otherwise the outcome is `evt_rsp`, and 16 bytes are accepted even when bit 7 is clear.
- R8: When bit 6 is clear, the outcome is always `evt_sent`, whatever bytes arrived.
- R9: A timeout or sent outcome leaves `rsp_words` unchanged.
- R10: `card_nores` ends the exchange as if no byte had been received, discarding any bytes already collected.
- R11: Bytes presented on `card_byte_vld` outside the wait-for-response phase are ignored. This includes the request cycle and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 11 | Command word: 5:0 index, 6 response expected, 7 long response, 10 start |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_q | output | 11 | Command register read-back |
| cmd_active | output | 1 | Command in progress |
| card_req | output | 1 | One-cycle request to the card engine |
| card_idx | output | 6 | Command index to the card engine |
| card_arg | output | 32 | Argument to the card engine |
| card_byte_vld | input | 1 | Response byte valid |
| card_byte | input | 8 | Response byte |
| card_done | input | 1 | Card engine finished the exchange |
| card_nores | input | 1 | Card engine saw no response |
| rsp_words | output | 128 | Four response words, word 0 in bits 31:0 |
| evt_sent | output | 1 | Pulse: command sent, no response expected |
| evt_rsp | output | 1 | Pulse: valid response received |
| evt_tmo | output | 1 | Pulse: command timeout |

## Verification
Two functions can fall in the same cycle here.

The first case is the final response byte arriving in the cycle that also signals `card_done`. The bench drives this case for every odd byte count in its sweep. It judges the case by the outcome and the packed words, which are computed arithmetically from the byte count. A lost or doubled byte changes the count, and with it the outcome or the words.

The second case is a new command write landing in the final busy cycle, while completion is clearing the start bit. The bench makes such a write on every command. It then confirms that the read-back shows the original command with only the start bit cleared, and that the argument is unchanged.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_ISSUE  = 2'd1,
      SEQ_WAIT   = 2'd2,
      SEQ_FINISH = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_SENT = 2'd1,
      OUT_RSP  = 2'd2,
      OUT_TMO  = 2'd3
   } outcome_t;
endpackage

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
   import sdcmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       card_done,
   input  logic       card_nores,
   output seq_state_t state,
   output logic       nores_seen
);
   seq_state_t state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         SEQ_IDLE:   if (start) state_nx = SEQ_ISSUE;
         SEQ_ISSUE:  state_nx = SEQ_WAIT;
         SEQ_WAIT:   if (card_done || card_nores) state_nx = SEQ_FINISH;
         SEQ_FINISH: state_nx = SEQ_IDLE;
         default:    state_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         nores_seen <= 1'b0;
      end else begin
         state <= state_nx;
         if (start && state == SEQ_IDLE)
            nores_seen <= 1'b0;
         else if (state == SEQ_WAIT && card_nores)
            nores_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/sdcmd_capture.sv
module sdcmd_capture #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 16,
   parameter int CNT_W     = $clog2(MAX_BYTES + 2)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        enable,
   input  logic                        byte_vld,
   input  logic [BYTE_W-1:0]           byte_in,
   output logic [CNT_W-1:0]            cnt,
   output logic [MAX_BYTES*BYTE_W-1:0] buf_flat
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BYTES + 1);

   if ((1 << CNT_W) <= MAX_BYTES + 1) begin : g_bad_cnt
      $error("sdcmd_capture: CNT_W too narrow for MAX_BYTES");
   end

   logic take;
   assign take = enable && byte_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (take && cnt != CNT_SAT)
         cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (take && cnt == CNT_W'(g))
            slot_q <= byte_in;
      end
      assign buf_flat[g*BYTE_W +: BYTE_W] = slot_q;
   end
endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge
   import sdcmd_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int WORD_W      = 32,
   parameter int SHORT_BYTES = 4,
   parameter int LONG_BYTES  = 16,
   parameter int CNT_W       = $clog2(LONG_BYTES + 2)
) (
   input  logic                         want_rsp,
   input  logic                         want_long,
   input  logic [CNT_W-1:0]             cnt,
   input  logic [LONG_BYTES*BYTE_W-1:0] buf_flat,
   output outcome_t                     outcome,
   output logic [LONG_BYTES*BYTE_W-1:0] words_flat
);
   localparam int BPW = WORD_W / BYTE_W;
   localparam int NW  = LONG_BYTES / BPW;
   localparam int SW  = SHORT_BYTES / BPW;

   if (WORD_W % BYTE_W != 0 || LONG_BYTES % BPW != 0 || SHORT_BYTES % BPW != 0) begin : g_bad_geom
      $error("sdcmd_judge: response sizes must be whole words");
   end
   if (SHORT_BYTES >= LONG_BYTES || SHORT_BYTES == 0) begin : g_bad_len
      $error("sdcmd_judge: short response must be non-empty and shorter than long");
   end

   logic is_short, is_long;
   assign is_short = (cnt == CNT_W'(SHORT_BYTES));
   assign is_long  = (cnt == CNT_W'(LONG_BYTES));

   logic [LONG_BYTES*BYTE_W-1:0] raw;

   for (genvar w = 0; w < NW; w++) begin : g_word
      for (genvar b = 0; b < BPW; b++) begin : g_byte
         assign raw[w*WORD_W + WORD_W - BYTE_W*(b+1) +: BYTE_W] =
            buf_flat[(w*BPW + b)*BYTE_W +: BYTE_W];
      end
      if (w == NW - 1) begin : g_last
         assign words_flat[w*WORD_W +: WORD_W] =
            is_long ? {raw[w*WORD_W + 1 +: WORD_W - 1], 1'b0} : '0;
      end else if (w >= SW) begin : g_upper
         assign words_flat[w*WORD_W +: WORD_W] =
            is_long ? raw[w*WORD_W +: WORD_W] : '0;
      end else begin : g_lower
         assign words_flat[w*WORD_W +: WORD_W] = raw[w*WORD_W +: WORD_W];
      end
   end

   always_comb begin
      if (!want_rsp)
         outcome = OUT_SENT;
      else if (is_long || (is_short && !want_long))
         outcome = OUT_RSP;
      else
         outcome = OUT_TMO;
   end
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
   import sdcmd_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int ARG_W       = 32,
   parameter int CMD_W       = 11,
   parameter int RSP_BIT     = 6,
   parameter int LONG_BIT    = 7,
   parameter int EN_BIT      = 10,
   parameter int BYTE_W      = 8,
   parameter int WORD_W      = 32,
   parameter int SHORT_BYTES = 4,
   parameter int LONG_BYTES  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_wr,
   input  logic [CMD_W-1:0]             cmd_wdata,
   input  logic                         arg_wr,
   input  logic [ARG_W-1:0]             arg_wdata,
   output logic [CMD_W-1:0]             cmd_q,
   output logic                         cmd_active,
   output logic                         card_req,
   output logic [IDX_W-1:0]             card_idx,
   output logic [ARG_W-1:0]             card_arg,
   input  logic                         card_byte_vld,
   input  logic [BYTE_W-1:0]            card_byte,
   input  logic                         card_done,
   input  logic                         card_nores,
   output logic [LONG_BYTES*BYTE_W-1:0] rsp_words,
   output logic                         evt_sent,
   output logic                         evt_rsp,
   output logic                         evt_tmo
);
   localparam int CNT_W = $clog2(LONG_BYTES + 2);

   if (IDX_W > CMD_W || RSP_BIT >= CMD_W || LONG_BIT >= CMD_W || EN_BIT >= CMD_W) begin : g_bad_fields
      $error("sdcmd_issuer: command fields exceed CMD_W");
   end
   if (EN_BIT != CMD_W - 1) begin : g_bad_en
      $error("sdcmd_issuer: start bit must be the top command bit");
   end

   seq_state_t                  state;
   logic                        nores_seen;
   logic                        start, finish;
   logic [CNT_W-1:0]            cnt, cnt_eff;
   logic [LONG_BYTES*BYTE_W-1:0] buf_flat, words_nx;
   outcome_t                    outcome;
   logic [ARG_W-1:0]            arg_q;

   assign cmd_active = (state != SEQ_IDLE);
   assign start      = cmd_wr && !cmd_active && cmd_wdata[EN_BIT];
   assign finish     = (state == SEQ_FINISH);
   assign card_req   = (state == SEQ_ISSUE);
   assign card_idx   = cmd_q[IDX_W-1:0];
   assign card_arg   = arg_q;
   assign cnt_eff    = nores_seen ? '0 : cnt;

   sdcmd_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .card_done  (card_done),
      .card_nores (card_nores),
      .state      (state),
      .nores_seen (nores_seen)
   );

   sdcmd_capture #(
      .BYTE_W    (BYTE_W),
      .MAX_BYTES (LONG_BYTES),
      .CNT_W     (CNT_W)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .enable   (state == SEQ_WAIT),
      .byte_vld (card_byte_vld),
      .byte_in  (card_byte),
      .cnt      (cnt),
      .buf_flat (buf_flat)
   );

   sdcmd_judge #(
      .BYTE_W      (BYTE_W),
      .WORD_W      (WORD_W),
      .SHORT_BYTES (SHORT_BYTES),
      .LONG_BYTES  (LONG_BYTES),
      .CNT_W       (CNT_W)
   ) u_judge (
      .want_rsp   (cmd_q[RSP_BIT]),
      .want_long  (cmd_q[LONG_BIT]),
      .cnt        (cnt_eff),
      .buf_flat   (buf_flat),
      .outcome    (outcome),
      .words_flat (words_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         arg_q <= '0;
      end else begin
         if (cmd_wr && !cmd_active)
            cmd_q <= cmd_wdata;
         else if (finish)
            cmd_q[EN_BIT] <= 1'b0;
         if (arg_wr && !cmd_active)
            arg_q <= arg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_words <= '0;
         evt_sent  <= 1'b0;
         evt_rsp   <= 1'b0;
         evt_tmo   <= 1'b0;
      end else begin
         evt_sent <= finish && (outcome == OUT_SENT);
         evt_rsp  <= finish && (outcome == OUT_RSP);
         evt_tmo  <= finish && (outcome == OUT_TMO);
         if (finish && outcome == OUT_RSP)
            rsp_words <= words_nx;
      end
   end
endmodule

// File: rtl/sdcmd_issuer_chk.sv
module sdcmd_issuer_chk #(
   parameter int CMD_W   = 11,
   parameter int EN_BIT  = 10,
   parameter int RSP_BIT = 6,
   parameter int WORD_W  = 32,
   parameter int RSP_W   = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CMD_W-1:0] cmd_q,
   input logic             cmd_active,
   input logic             card_req,
   input logic [RSP_W-1:0] rsp_words,
   input logic             evt_sent,
   input logic             evt_rsp,
   input logic             evt_tmo
);
   logic any_evt;
   assign any_evt = evt_sent || evt_rsp || evt_tmo;

   // R1
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_req |-> cmd_active);
   // R1
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_req |=> !card_req);
   // R1
   req_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_active) |-> card_req);
   // R2
   evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_sent, evt_rsp, evt_tmo}));
   // R2
   evt_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |-> (!cmd_active && !cmd_q[EN_BIT]));
   // R2
   fall_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_active) |-> any_evt);
   // R3
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_active |=> (cmd_q[EN_BIT-1:0] == $past(cmd_q[EN_BIT-1:0])));
   // R6
   last_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rsp |-> !rsp_words[RSP_W - WORD_W]);
   // R7
   tmo_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_tmo |-> cmd_q[RSP_BIT]);
   // R8
   sent_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_sent |-> !cmd_q[RSP_BIT]);
   // R9
   words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_rsp |-> $stable(rsp_words));
endmodule

bind sdcmd_issuer sdcmd_issuer_chk #(
   .CMD_W   (CMD_W),
   .EN_BIT  (EN_BIT),
   .RSP_BIT (RSP_BIT),
   .WORD_W  (WORD_W),
   .RSP_W   (LONG_BYTES*BYTE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_q      (cmd_q),
   .cmd_active (cmd_active),
   .card_req   (card_req),
   .rsp_words  (rsp_words),
   .evt_sent   (evt_sent),
   .evt_rsp    (evt_rsp),
   .evt_tmo    (evt_tmo)
);

// File: tb/tb_sdcmd_issuer.sv
module tb_sdcmd_issuer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_wr = 1'b0;
   logic [10:0]  cmd_wdata = '0;
   logic         arg_wr = 1'b0;
   logic [31:0]  arg_wdata = '0;
   logic [10:0]  cmd_q;
   logic         cmd_active, card_req;
   logic [5:0]   card_idx;
   logic [31:0]  card_arg;
   logic         card_byte_vld = 1'b0;
   logic [7:0]   card_byte = '0;
   logic         card_done = 1'b0;
   logic         card_nores = 1'b0;
   logic [127:0] rsp_words;
   logic         evt_sent, evt_rsp, evt_tmo;

   int n_chk = 0;
   int n_fail = 0;
   logic [127:0] exp_words = '0;

   always #10 clk = ~clk;

   sdcmd_issuer dut (.*);

   task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] bval(input int seed, input int k);
      return 8'((seed * 37 + k * 11 + 90) & 255);
   endfunction

   function automatic logic [31:0] mkword(input int seed, input int w);
      logic [31:0] r = '0;
      for (int b = 0; b < 4; b++) r[31 - 8*b -: 8] = bval(seed, 4*w + b);
      return r;
   endfunction

   task automatic run_cmd(input int idx, input bit rsp, input bit lng, input int n,
                          input bit nores, input bit stray, input bit merge, input int seed);
      logic [10:0] c;
      logic [31:0] a;
      int eff;
      int kind; // 1 sent, 2 rsp, 3 tmo
      c = {1'b1, 2'b00, lng, rsp, 6'(idx)};
      a = 32'h1234_0000 ^ 32'(seed * 32'h9E37);
      @(negedge clk); arg_wr = 1; arg_wdata = a;
      @(negedge clk); arg_wr = 0; cmd_wr = 1; cmd_wdata = c;
      @(negedge clk); cmd_wr = 0;
      check(cmd_active && card_req, "R1 start", {cmd_active, card_req}, 2'b11);
      check(card_idx == 6'(idx) && card_arg == a, "R1 fields", {card_idx, card_arg}, {6'(idx), a});
      if (stray) begin card_byte_vld = 1; card_byte = 8'hEE; end
      @(negedge clk); card_byte_vld = 0;
      check(!card_req && cmd_active, "R1 single req", {card_req, cmd_active}, 2'b01);
      for (int k = 0; k < n; k++) begin
         card_byte_vld = 1; card_byte = bval(seed, k);
         if (merge && k == n - 1) begin
            if (nores) card_nores = 1; else card_done = 1;
         end
         @(negedge clk);
         card_byte_vld = 0;
      end
      if (!(merge && n > 0)) begin
         if (nores) card_nores = 1; else card_done = 1;
         @(negedge clk);
      end
      card_done = 0; card_nores = 0;
      // final busy cycle: writes here must be ignored
      check(cmd_active && !(evt_sent | evt_rsp | evt_tmo), "R3 busy until finish",
            {cmd_active, evt_sent, evt_rsp, evt_tmo}, 4'b1000);
      cmd_wr = 1; cmd_wdata = ~c; arg_wr = 1; arg_wdata = ~a;
      @(negedge clk); cmd_wr = 0; arg_wr = 0;
      eff = nores ? 0 : n;
      if (!rsp) kind = 1;
      else if (eff == 16 || (eff == 4 && !lng)) kind = 2;
      else kind = 3;
      if (kind == 2) begin
         exp_words[31:0] = mkword(seed, 0);
         if (eff == 16) begin
            exp_words[63:32] = mkword(seed, 1);
            exp_words[95:64] = mkword(seed, 2);
            exp_words[127:96] = mkword(seed, 3) & 32'hFFFF_FFFE;
         end else exp_words[127:32] = '0;
      end
      check({evt_sent, evt_rsp, evt_tmo} == {kind == 1, kind == 2, kind == 3},
            rsp ? (nores ? "R10 outcome" : "R7 outcome") : "R8 outcome",
            {evt_sent, evt_rsp, evt_tmo}, {kind == 1, kind == 2, kind == 3});
      check(!cmd_active && cmd_q == {1'b0, c[9:0]}, "R2 enable cleared",
            {cmd_active, cmd_q}, {1'b0, 1'b0, c[9:0]});
      check(card_arg == a, "R3 arg write ignored", card_arg, a);
      check(rsp_words == exp_words,
            kind == 2 ? (eff == 16 ? "R6 long words" : "R5 short words") : "R9 words kept",
            rsp_words, exp_words);
      check(rsp_words[31:0] == exp_words[31:0], "R4 byte order", rsp_words[31:0], exp_words[31:0]);
      card_byte_vld = 1; card_byte = 8'h5C;
      @(negedge clk); card_byte_vld = 0;
      check(!(evt_sent | evt_rsp | evt_tmo) && rsp_words == exp_words, "R11 idle bytes ignored",
            rsp_words, exp_words);
   endtask

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!cmd_active && !card_req && cmd_q == '0 && rsp_words == '0 &&
            !(evt_sent | evt_rsp | evt_tmo), "R2 reset state",
            {cmd_active, card_req, cmd_q}, '0);
      // write without start bit
      cmd_wr = 1; cmd_wdata = 11'h0C5;
      @(negedge clk); cmd_wr = 0;
      check(cmd_q == 11'h0C5 && !cmd_active, "R1 no start", {cmd_active, cmd_q}, 12'h0C5);
      @(negedge clk);
      check(!card_req && !cmd_active, "R1 no request", {card_req, cmd_active}, 2'b00);
      for (int n = 0; n <= 18; n++)
         for (int r = 0; r < 2; r++)
            for (int l = 0; l < 2; l++)
               run_cmd((n * 3 + r * 17 + l * 29) & 63, r[0], l[0], n, 1'b0,
                       n == 4 || n == 16, n[0], n * 4 + r * 2 + l + 1);
      run_cmd(12, 1, 0, 4, 1, 0, 0, 200);
      run_cmd(13, 1, 1, 16, 1, 0, 1, 201);
      run_cmd(14, 0, 0, 3, 1, 0, 0, 202);
      run_cmd(15, 1, 0, 2, 1, 0, 0, 203);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule